// File: doc/BRIEF.md
# Dual-Lane Bidirectional Registered Transceiver

This block connects two 16-bit ports, A and B, through two independent 8-bit lanes. Each lane holds two storage registers. The forward register captures from port A and drives port B. The return register captures from port B and drives port A. Each direction of each lane has its own clock, its own active-low capture enable and its own active-low drive enable. The lanes can therefore move bytes in either direction on unrelated schedules. When the matching controls of both lanes are wired together, the pair acts as a single 16-bit transceiver.

Each port is modelled as an 8-bit value plus a one-bit drive flag per lane, so that the block stays synthesizable. The surrounding logic resolves those drivers into shared tri-state buses. A synchronous reset clears each register on the next rising edge of that register's own clock. The reset exists only to give simulation a known starting point.

Top module: `xcvr_dual`

## Requirements
- R1: The two lanes and the two directions are fully independent. A capture by any one of the four registers leaves the other three registers, and the outputs they drive, unchanged.
- R2: On a rising edge of a lane's forward clock `fw_clk`, with `fw_cap_n` at 0, that lane's byte of `a_in` is stored in the forward register.
- R3: On a rising edge of `fw_clk` with `fw_cap_n` at 1, the forward register keeps its old contents, and `b_out` keeps showing them.
- R4: While no rising edge arrives on `fw_clk`, the forward register holds its contents whatever `fw_cap_n` and `a_in` do.
- R5: While `fw_drv_n` is 1, that lane's `b_drv` bit is 0, so port B is not driven. This holds regardless of clock, capture enable or data. The stored value survives the disabled period.
- R6: While `fw_drv_n` is 0, `b_drv` is 1 and `b_out` carries the stored forward value, never the live `a_in`.
- R7: The return direction behaves as R2 to R6 do. It uses `rv_clk`, `rv_cap_n` and `rv_drv_n`, captures from `b_in` and drives `a_out`/`a_drv`.
- R8: With both lanes' matching controls tied together, a 16-bit word on `a_in` is captured and presented whole on `b_out` (lane 0 = bits 7:0, lane 1 = bits 15:8).
- R9: While `rst` is 1, each register becomes 0 at the next rising edge of its own clock.
- R10: With both directions of a lane enabled at once, each port carries only its own register's value. Each capture takes the external input (`a_in`/`b_in`), never the lane's own output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous reset, active high, taken on each register's own clock |
| fw_clk | input | 2 | Per-lane A-to-B capture clock |
| fw_cap_n | input | 2 | Per-lane A-to-B capture enable, active low |
| fw_drv_n | input | 2 | Per-lane B-port drive enable, active low |
| rv_clk | input | 2 | Per-lane B-to-A capture clock |
| rv_cap_n | input | 2 | Per-lane B-to-A capture enable, active low |
| rv_drv_n | input | 2 | Per-lane A-port drive enable, active low |
| a_in | input | 16 | Value seen on port A |
| b_in | input | 16 | Value seen on port B |
| b_out | output | 16 | Forward register contents presented to port B |
| b_drv | output | 2 | Per-lane B-port driver active |
| a_out | output | 16 | Return register contents presented to port A |
| a_drv | output | 2 | Per-lane A-port driver active |

## Verification
A captured value appears on the opposite port straight after the rising edge of the capturing clock, with no further register stage. Each check therefore samples at the next falling edge of the bench clock, after the pulse. Drive flags follow the drive-enable pins with no clock at all, and the bench reads them a short delay after changing those pins. To show that a register has held (R3, R4), the bench changes the data first and then samples after one or more idle clock periods, or after an edge with the capture enable high. A stale value is then told apart from a fresh capture.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    localparam int LANE_W = 8;
    typedef logic [LANE_W-1:0] lane_t;
    typedef struct packed {
        lane_t data;
    } dir_state_t;
endpackage

// File: rtl/xcvr_dir_reg.sv
module xcvr_dir_reg
    import xcvr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap_n,
    input  logic  drv_n,
    input  lane_t din,
    output lane_t dout,
    output logic  drv
);
    dir_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.data = '0;
        end else if (!cap_n) begin
            st_d.data = din;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.data;
    assign drv  = ~drv_n;

    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !cap_n |=> dout == $past(din));                       // R2
    AST_HOLD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        cap_n |=> $stable(dout));                             // R3
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> dout == '0);                                  // R9
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
(
    input  logic  rst,
    input  logic  fw_clk,
    input  logic  fw_cap_n,
    input  logic  fw_drv_n,
    input  logic  rv_clk,
    input  logic  rv_cap_n,
    input  logic  rv_drv_n,
    input  lane_t a_in,
    input  lane_t b_in,
    output lane_t b_out,
    output logic  b_drv,
    output lane_t a_out,
    output logic  a_drv
);
    // forward path: port A -> register -> port B
    xcvr_dir_reg u_fw (
        .clk(fw_clk), .rst(rst), .cap_n(fw_cap_n), .drv_n(fw_drv_n),
        .din(a_in), .dout(b_out), .drv(b_drv)
    );
    // return path: port B -> register -> port A (takes b_in, not b_out)
    xcvr_dir_reg u_rv (
        .clk(rv_clk), .rst(rst), .cap_n(rv_cap_n), .drv_n(rv_drv_n),
        .din(b_in), .dout(a_out), .drv(a_drv)
    );

    AST_FW_DRIVES_STORED: assert property (@(posedge fw_clk) disable iff (rst)
        (!fw_cap_n && !fw_drv_n) |=> (b_drv && b_out == $past(a_in)));   // R6
    AST_RV_DRIVES_STORED: assert property (@(posedge rv_clk) disable iff (rst)
        (!rv_cap_n && !rv_drv_n) |=> (a_drv && a_out == $past(b_in)));   // R7
endmodule

// File: rtl/xcvr_dual.sv
module xcvr_dual
    import xcvr_pkg::*;
#(
    parameter int LANES = 2,
    localparam int BUS_W = LANES * LANE_W
) (
    input  logic             rst,
    input  logic [LANES-1:0] fw_clk,
    input  logic [LANES-1:0] fw_cap_n,
    input  logic [LANES-1:0] fw_drv_n,
    input  logic [LANES-1:0] rv_clk,
    input  logic [LANES-1:0] rv_cap_n,
    input  logic [LANES-1:0] rv_drv_n,
    input  logic [BUS_W-1:0] a_in,
    input  logic [BUS_W-1:0] b_in,
    output logic [BUS_W-1:0] b_out,
    output logic [LANES-1:0] b_drv,
    output logic [BUS_W-1:0] a_out,
    output logic [LANES-1:0] a_drv
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        xcvr_lane u_lane (
            .rst     (rst),
            .fw_clk  (fw_clk[g]),
            .fw_cap_n(fw_cap_n[g]),
            .fw_drv_n(fw_drv_n[g]),
            .rv_clk  (rv_clk[g]),
            .rv_cap_n(rv_cap_n[g]),
            .rv_drv_n(rv_drv_n[g]),
            .a_in    (a_in[g*LANE_W +: LANE_W]),
            .b_in    (b_in[g*LANE_W +: LANE_W]),
            .b_out   (b_out[g*LANE_W +: LANE_W]),
            .b_drv   (b_drv[g]),
            .a_out   (a_out[g*LANE_W +: LANE_W]),
            .a_drv   (a_drv[g])
        );
    end
endmodule

// File: tb/sim_xcvr_dual.sv
`timescale 1ns/1ps
module sim_xcvr_dual;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic [1:0]  fw_clk = '0, fw_cap_n = '1, fw_drv_n = '1;
    logic [1:0]  rv_clk = '0, rv_cap_n = '1, rv_drv_n = '1;
    logic [15:0] a_in = '0, b_in = '0;
    logic [15:0] b_out, a_out;
    logic [1:0]  b_drv, a_drv;
    int total = 0, bad = 0;
    bit done = 0;

    xcvr_dual u0 (.*);

    // resolved shared buses as seen from outside
    wire [15:0] a_bus, b_bus;
    for (genvar l = 0; l < 2; l++) begin : g_res
        assign b_bus[l*8 +: 8] = b_drv[l] ? b_out[l*8 +: 8] : 8'hzz;
        assign a_bus[l*8 +: 8] = a_drv[l] ? a_out[l*8 +: 8] : 8'hzz;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [1:0] fm, input logic [1:0] rm);
        @(posedge clk); #2;
        fw_clk = fm; rv_clk = rm;
        @(negedge clk);
        fw_clk = '0; rv_clk = '0;
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        a_in = 16'hFFFF; b_in = 16'hFFFF;
        pulse(2'b11, 2'b11);
        rst = 1'b0;
        fw_drv_n = '0; rv_drv_n = '0; #1;
        chk("R9 b_bus", b_bus, 16'h0000);
        chk("R9 a_bus", a_bus, 16'h0000);
    endtask

    task automatic t_fw_capture();
        fw_cap_n = 2'b10; a_in = 16'h33A5; b_in = 16'h4444;
        pulse(2'b01, 2'b00);
        chk("R2 lane0 b", b_bus, 16'h00A5);
        chk("R1 others untouched a", a_bus, 16'h0000);
        fw_cap_n = 2'b01; a_in = 16'hC300;
        pulse(2'b10, 2'b00);
        chk("R1 lane1 capture keeps lane0", b_bus, 16'hC3A5);
    endtask

    task automatic t_blocked();
        fw_cap_n = 2'b11; a_in = 16'h1E3C;
        pulse(2'b11, 2'b00);
        chk("R3 blocked edge", b_out, 16'hC3A5);
    endtask

    task automatic t_no_edge();
        fw_cap_n = 2'b00; a_in = 16'h7777;
        repeat (3) @(negedge clk);
        #1;
        chk("R4 R6 no edge, not live", b_bus, 16'hC3A5);
        fw_cap_n = 2'b11;
    endtask

    task automatic t_drive_off();
        fw_drv_n = 2'b01; #1;
        chk("R5 lane0 released", {14'b0, b_drv}, 16'h0002);
        chk("R5 bus z", b_bus, 16'hC3zz);
        fw_cap_n = 2'b10; a_in = 16'h0099;
        pulse(2'b01, 2'b00);
        chk("R5 still released after edge", b_bus, 16'hC3zz);
        fw_drv_n = 2'b00; #1;
        chk("R5 R6 value kept", b_bus, 16'hC399);
        fw_cap_n = 2'b11;
    endtask

    task automatic t_return();
        rv_cap_n = 2'b01; b_in = 16'h5A12; a_in = 16'h0000;
        pulse(2'b00, 2'b10);
        chk("R7 lane1 a", a_bus, 16'h5A00);
        chk("R1 forward kept", b_bus, 16'hC399);
        rv_cap_n = 2'b11; b_in = 16'hFFFF;
        pulse(2'b00, 2'b11);
        chk("R7 blocked", a_bus, 16'h5A00);
        rv_drv_n = 2'b10; #1;
        chk("R7 release", a_bus, 16'hzz00);
        rv_drv_n = 2'b00; #1;
    endtask

    task automatic t_both_dirs();
        fw_cap_n = 2'b10; rv_cap_n = 2'b10;
        a_in = 16'h0011; b_in = 16'h0022;
        pulse(2'b01, 2'b01);
        chk("R10 port B", b_bus, 16'hC311);
        chk("R10 port A", a_bus, 16'h5A22);
        pulse(2'b01, 2'b01);
        chk("R10 no loop B", b_bus, 16'hC311);
        chk("R10 no loop A", a_bus, 16'h5A22);
        fw_cap_n = 2'b11; rv_cap_n = 2'b11;
    endtask

    task automatic t_wide();
        fw_cap_n = 2'b00; a_in = 16'hBEEF;
        pulse(2'b11, 2'b00);
        chk("R8 16-bit word", b_bus, 16'hBEEF);
        rv_cap_n = 2'b00; b_in = 16'hCAFE;
        pulse(2'b00, 2'b11);
        chk("R8 16-bit return", a_bus, 16'hCAFE);
        fw_cap_n = 2'b11; rv_cap_n = 2'b11;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_fw_capture();
        t_blocked();
        t_no_edge();
        t_drive_off();
        t_return();
        t_both_dirs();
        t_wide();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end
endmodule